// File: doc/BRIEF.md
# Recursive Vertical-and-Crosswise Multiplier

This block multiplies two unsigned 16-bit operands and returns the full 32-bit product with no clock, no registers and no handshake: the product follows the operands combinationally. It suits a datapath that already has its own register stages on each side and needs a fixed-width unsigned product inside a single cycle.

The product is built recursively. At the bottom, a 2 x 2 cell forms four single-bit products and merges them with two half adders. Every larger size splits each operand into a high and a low half and forms the four half-size products in parallel. Three adders then merge them. The first adds the two cross products. The second adds that sum to the upper half of the low-by-low product. The third adds the high-by-high product to the result and folds in the two intermediate carries. The low half of the low-by-low product passes straight through to the lowest product bits. The 4 x 4 level uses plain ripple-carry adders. The 8 x 8 and 16 x 16 levels use carry-select adders. In these, each upper segment is one ripple adder with a zero carry-in plus an increment-by-one circuit, and a multiplexer picks between them on the incoming carry.

The block has no states or transitions. It is a pure function of its two inputs.

Top module: `vedic_mul16`

## Requirements
- R1: For every pair of 16-bit unsigned operands, `product` equals the unsigned product `op_a * op_b` over all 32 bits, settled within the same cycle in which the operands change.
- R2: When either operand is 0x0000, `product` is 0x00000000.
- R3: When one operand is 0x0001, `product` equals the other operand, zero-extended to 32 bits.
- R4: With both operands at 0xFFFF, `product` is 0xFFFE0001. The result never needs more than 32 bits.
- R5: Product bit 0 is op_a[0] AND op_b[0]. Product bit 1 is (op_a[1] AND op_b[0]) XOR (op_a[0] AND op_b[1]).
- R6: When one operand has a single bit k set, `product` equals the other operand shifted left by k, for every k from 0 to 15.
- R7: Operand patterns whose cross products carry across every 4-bit carry-select segment boundary give correct products. These include alternating 0xAAAA / 0x5555 in all four pairings, and all-ones against alternating values.
- R8: The product does not depend on operand order: swapping `op_a` and `op_b` leaves `product` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | Unsigned multiplicand |
| op_b | input | 16 | Unsigned multiplier |
| product | output | 32 | Unsigned product op_a * op_b |

## Verification
The bench builds the block with its default width of 16. This instantiates all four recursion levels, from the 2 x 2 leaf up to 16 x 16. Ripple adders are used at the 4-bit level. Carry-select adders with 4-bit segments are used at the 8-bit and 16-bit levels, so the increment path and the segment multiplexers lie on the path of every check. Directed corners (zero, one, all ones, alternating bits, single-bit operands) drive carries through each segment boundary. A long pseudo-random run then compares every product against an independently computed reference multiplication.

// File: rtl/vm_pkg.sv
package vm_pkg;
    // Smallest recursion level that merges partial products with carry-select adders
    localparam int CSA_FROM_LEVEL = 8;
    // Segment width inside each carry-select adder
    localparam int CSA_SEG = 4;

    function automatic bit level_uses_csa(input int level_n);
        return (level_n >= CSA_FROM_LEVEL);
    endfunction
endpackage

// File: rtl/vm_leaf2.sv
module vm_leaf2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    output logic [3:0] p
);
    logic pp00, pp01, pp10, pp11;
    logic ha1_s, ha1_c, ha2_s, ha2_c;

    always_comb begin
        pp00  = a[0] & b[0];
        pp10  = a[1] & b[0];
        pp01  = a[0] & b[1];
        pp11  = a[1] & b[1];
        ha1_s = pp10 ^ pp01;
        ha1_c = pp10 & pp01;
        ha2_s = ha1_c ^ pp11;
        ha2_c = ha1_c & pp11;
        p     = {ha2_c, ha2_s, ha1_s, pp00};
    end

    // Leaf product must match the arithmetic 2x2 product (R5, R1)
    always_comb begin
        assert_leaf_product_R5: assert (p == ({2'b00, a} * {2'b00, b}))
            else $error("leaf product mismatch");
    end
endmodule

// File: rtl/vm_rca.sv
module vm_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    always_comb begin
        carry[0] = cin;
        for (int i = 0; i < W; i++) begin
            sum[i]     = a[i] ^ b[i] ^ carry[i];
            carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
        end
        cout = carry[W];
    end

    always_comb begin
        assert_rca_sum_R1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
            else $error("ripple adder sum mismatch");
    end
endmodule

// File: rtl/vm_inc.sv
module vm_inc #(
    parameter int W = 5
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    logic [W:0] run_and;

    always_comb begin
        run_and[0] = 1'b1;
        for (int i = 0; i < W; i++) begin
            y[i]         = x[i] ^ run_and[i];
            run_and[i+1] = run_and[i] & x[i];
        end
    end

    always_comb begin
        assert_inc_value_R7: assert ((y == x + W'(1)) || (x == {W{1'b1}}))
            else $error("increment circuit mismatch");
    end
endmodule

// File: rtl/vm_adder.sv
module vm_adder #(
    parameter int W       = 8,
    parameter bit USE_CSA = 1'b0,
    parameter int SEG     = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int NSEG = (W + SEG - 1) / SEG;

    generate
        if (!USE_CSA || W <= SEG || (W % SEG) != 0) begin : g_ripple
            vm_rca #(.W(W)) u_rca (
                .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
            );
        end else begin : g_csa
            logic [NSEG:0] seg_c;
            assign seg_c[0] = cin;

            vm_rca #(.W(SEG)) u_seg0 (
                .a(a[SEG-1:0]), .b(b[SEG-1:0]), .cin(seg_c[0]),
                .sum(sum[SEG-1:0]), .cout(seg_c[1])
            );

            for (genvar k = 1; k < NSEG; k++) begin : g_seg
                logic [SEG-1:0] raw_s;
                logic           raw_c;
                logic [SEG:0]   inc_v;

                vm_rca #(.W(SEG)) u_raw (
                    .a(a[k*SEG +: SEG]), .b(b[k*SEG +: SEG]), .cin(1'b0),
                    .sum(raw_s), .cout(raw_c)
                );
                vm_inc #(.W(SEG+1)) u_inc (
                    .x({raw_c, raw_s}), .y(inc_v)
                );
                assign {seg_c[k+1], sum[k*SEG +: SEG]} =
                    seg_c[k] ? inc_v : {raw_c, raw_s};
            end
            assign cout = seg_c[NSEG];
        end
    endgenerate

    always_comb begin
        assert_adder_sum_R7: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
            else $error("merge adder sum mismatch");
    end
endmodule

// File: rtl/vm_node.sv
module vm_node #(
    parameter int N = 16
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    import vm_pkg::*;
    localparam int H       = N / 2;
    localparam bit USE_CSA = level_uses_csa(N);

    generate
        if (N == 2) begin : g_leaf
            vm_leaf2 u_leaf (.a(a), .b(b), .p(p));
        end else begin : g_split
            logic [N-1:0] p_ll, p_lh, p_hl, p_hh;
            logic [N-1:0] cross_sum, mid_sum, top_sum, mid_b, top_b;
            logic         cross_c, mid_c, top_c;

            vm_node #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
            vm_node #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(p_hl));
            vm_node #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(p_lh));
            vm_node #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(p_hh));

            // first merge: the two cross products
            vm_adder #(.W(N), .USE_CSA(USE_CSA), .SEG(CSA_SEG)) u_add_cross (
                .a(p_hl), .b(p_lh), .cin(1'b0), .sum(cross_sum), .cout(cross_c)
            );

            // second merge: upper half of low product, zero-extended
            always_comb begin
                mid_b        = '0;
                mid_b[H-1:0] = p_ll[N-1:H];
            end
            vm_adder #(.W(N), .USE_CSA(USE_CSA), .SEG(CSA_SEG)) u_add_mid (
                .a(cross_sum), .b(mid_b), .cin(1'b0), .sum(mid_sum), .cout(mid_c)
            );

            // third merge: high product plus upper middle bits and both carries
            always_comb begin
                top_b          = '0;
                top_b[H-1:0]   = mid_sum[N-1:H];
                top_b[H +: 2]  = {cross_c & mid_c, cross_c ^ mid_c};
            end
            vm_adder #(.W(N), .USE_CSA(USE_CSA), .SEG(CSA_SEG)) u_add_top (
                .a(p_hh), .b(top_b), .cin(1'b0), .sum(top_sum), .cout(top_c)
            );

            assign p = {top_sum, mid_sum[H-1:0], p_ll[H-1:0]};

            // the full product always fits, so the last merge never carries out (R4)
            always_comb begin
                assert_no_overflow_R4: assert (top_c == 1'b0)
                    else $error("top merge carried out");
            end
        end
    endgenerate

    always_comb begin
        assert_node_product_R1: assert (p == ({{N{1'b0}}, a} * {{N{1'b0}}, b}))
            else $error("node product mismatch");
    end
endmodule

// File: rtl/vedic_mul16.sv
module vedic_mul16 #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]   op_a,
    input  logic [WIDTH-1:0]   op_b,
    output logic [2*WIDTH-1:0] product
);
    vm_node #(.N(WIDTH)) u_root (
        .a(op_a), .b(op_b), .p(product)
    );

    always_comb begin
        assert_zero_operand_R2: assert (!((op_a == '0) || (op_b == '0)) || (product == '0))
            else $error("zero operand gave nonzero product");
    end
endmodule

// File: tb/vedic_mul16_tb.sv
module vedic_mul16_tb;
    logic        clk = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic [31:0] product;
    int          checks = 0;
    int          failures = 0;
    int          cycles = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    vedic_mul16 u_dut (.op_a(op_a), .op_b(op_b), .product(product));

    task automatic check(input string req, input logic [31:0] exp);
        checks++;
        if (product !== exp) begin
            failures++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, op_a, op_b, product, exp);
        end
    endtask

    task automatic apply(input logic [15:0] x, input logic [15:0] y);
        @(posedge clk);
        op_a <= x;
        op_b <= y;
        @(negedge clk);
    endtask

    task automatic ref_check(input string req, input logic [15:0] x, input logic [15:0] y);
        apply(x, y);
        check(req, {16'h0, x} * {16'h0, y});
    endtask

    task automatic t_idle;
        @(negedge clk);
        check("R2 idle", 32'h0);
    endtask

    task automatic t_zero;
        logic [15:0] vals [4] = '{16'h0001, 16'hFFFF, 16'hAAAA, 16'h1234};
        foreach (vals[i]) begin
            apply(16'h0000, vals[i]); check("R2", 32'h0);
            apply(vals[i], 16'h0000); check("R2", 32'h0);
        end
    endtask

    task automatic t_one;
        logic [15:0] vals [4] = '{16'hFFFF, 16'h5555, 16'h8001, 16'h0001};
        foreach (vals[i]) begin
            apply(16'h0001, vals[i]); check("R3", {16'h0, vals[i]});
            apply(vals[i], 16'h0001); check("R3", {16'h0, vals[i]});
        end
    endtask

    task automatic t_max;
        apply(16'hFFFF, 16'hFFFF);
        check("R4", 32'hFFFE0001);
    endtask

    task automatic t_low_bits;
        for (int x = 0; x < 4; x++) begin
            for (int y = 0; y < 4; y++) begin
                logic [1:0] xa = 2'(x);
                logic [1:0] yb = 2'(y);
                apply({14'h2A5C >> 0, xa} ^ 16'h0, {14'h1F3B, yb});
                checks++;
                if (product[1:0] !== {(xa[1] & yb[0]) ^ (xa[0] & yb[1]), xa[0] & yb[0]}) begin
                    failures++;
                    $display("FAIL R5 a=%h b=%h actual=%b expected=%b", op_a, op_b, product[1:0],
                             {(xa[1] & yb[0]) ^ (xa[0] & yb[1]), xa[0] & yb[0]});
                end
            end
        end
    endtask

    task automatic t_shift;
        for (int k = 0; k < 16; k++) begin
            apply(16'h1 << k, 16'hB7C9);
            check("R6", 32'h0000B7C9 << k);
            apply(16'hFFFF, 16'h1 << k);
            check("R6", 32'h0000FFFF << k);
        end
    endtask

    task automatic t_carry_patterns;
        logic [15:0] pat [4] = '{16'hAAAA, 16'h5555, 16'hFFFF, 16'hF0F0};
        foreach (pat[i]) begin
            foreach (pat[j]) ref_check("R7", pat[i], pat[j]);
        end
        ref_check("R7", 16'h0FFF, 16'hFFF1);
        ref_check("R7", 16'h7FFF, 16'h8001);
    endtask

    task automatic t_random;
        logic [31:0] s = 32'h1ACE_B00C;
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] prod_ab;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            ref_check("R1", s[15:0], s[31:16]);
            prod_ab = product;
            apply(s[31:16], s[15:0]);
            check("R8", prod_ab);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_zero();
        t_one();
        t_max();
        t_low_bits();
        t_shift();
        t_carry_patterns();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule